// File: doc/BRIEF.md
# Eight-Stage Pipeline Operand Interlock

This block holds back the decode stage of an in-order, eight-stage pipeline until every register operand that decode needs has been written back. The stages run in order: two instruction-fetch stages, decode, two execute stages, two memory stages and writeback. Operands are read in decode and results are written in writeback. The register file cannot hand a value to a read in the same cycle it is written, and no forwarding paths exist. So a consumer can leave decode only in a cycle strictly after its producer's writeback cycle.

Each stage is modelled only by a small register that holds a valid bit, a write-enable and a destination register number. The fetch and decode stages also hold the two source register numbers. Each cycle, the two decode sources are compared against the destinations of all valid, write-enabled instructions in the five stages from first execute through writeback. On a match the front three stages freeze and the first execute stage takes an empty slot. Branch, structural and memory hazards are not handled here.

The number of execute and memory stages are parameters. The register-number width comes from the shared package (5 bits, 32 registers).

Top module: `pipe_interlock`

## Requirements
- R1: After reset every stage is empty: `stall` is 0, `fetch_ready` is 1, `ex1_valid` and `wb_valid` are 0.
- R2: A decode source register that is nonzero and equal to the destination of a valid, write-enabled instruction in any of EX1, EX2, DM1, DM2 or WB raises `stall` in that cycle.
- R3: A consumer that directly follows its producer leaves decode exactly 6 cycles after the producer, which is 5 stall cycles. `stall` is never high for more than 5 consecutive cycles.
- R4: A consumer two instructions behind its producer leaves decode exactly 5 cycles after the instruction just ahead of it, which is 4 stall cycles.
- R5: Register number 0 never creates a hazard, whether as a source or as a destination.
- R6: A producer whose write-enable is 0 creates no hazard.
- R7: While `stall` is high, `fetch_ready` is 0 and IM1, IM2 and ID hold their contents. Instructions reach EX1 in program order, with none lost and none duplicated.
- R8: In every cycle that follows a stall cycle, EX1 holds a bubble (`ex1_valid` is 0). Stages EX2 through WB keep advancing, so instructions retire at `wb_valid`/`wb_rd` in program order.
- R9: With no hazard, one instruction moves from decode into EX1 every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction is offered to IM1 |
| fetch_we | input | 1 | Offered instruction writes its destination |
| fetch_rd | input | 5 | Destination register number |
| fetch_rs1 | input | 5 | First source register number |
| fetch_rs2 | input | 5 | Second source register number |
| fetch_ready | output | 1 | IM1 accepts the offered instruction at the next edge |
| stall | output | 1 | Decode hazard present; front stages hold |
| ex1_valid | output | 1 | EX1 holds a real instruction |
| ex1_rd | output | 5 | Destination register number in EX1 |
| wb_valid | output | 1 | WB holds a real instruction |
| wb_we | output | 1 | Write-enable of the WB instruction |
| wb_rd | output | 5 | Destination register number in WB |

## Verification
The stall decision depends only on state, so any wrong state shows up in the spacing between instructions entering EX1. If a stage entry is dropped or a compare is missing, a dependent instruction reaches EX1 early, and its gap to the instruction ahead comes out shorter than the scoreboard predicts. A spurious match or a stuck stage shows up the other way, as an extra stall cycle or a duplicated or missing `ex1_rd`. A wrong write-back order appears at `wb_rd` four cycles after issue. Every issue gap is checked against a bench model of the register ready cycles, so a fault is reported at the first dependent instruction it affects.

// File: rtl/pi_pkg.sv
package pi_pkg;

   localparam int REG_IDX_W = 5;

   // front-end stage: carries sources for the decode compare
   typedef struct packed {
      logic                 valid;
      logic                 we;
      logic [REG_IDX_W-1:0] rd;
      logic [REG_IDX_W-1:0] rs1;
      logic [REG_IDX_W-1:0] rs2;
   } front_t;

   // back-end stage: only what the hazard compare needs
   typedef struct packed {
      logic                 valid;
      logic                 we;
      logic [REG_IDX_W-1:0] rd;
   } dest_t;

endpackage

// File: rtl/pi_front.sv
module pi_front
   import pi_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   hold,
   input  front_t fetch_in,
   output front_t id_out
);

   front_t stg_q [DEPTH];

   initial assert (DEPTH >= 2) else $error("pi_front: DEPTH must be at least 2");

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stg_q[i] <= '0;
            else if (!hold)
               stg_q[i] <= (i == 0) ? fetch_in : stg_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign id_out = stg_q[DEPTH-1];

   // R7: a held decode slot does not change
   p_front_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(stg_q[DEPTH-1]));

endmodule

// File: rtl/pi_back.sv
module pi_back
   import pi_pkg::*;
#(
   parameter int DEPTH = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bubble,
   input  front_t               id_in,
   output dest_t [DEPTH-1:0]    stg
);

   dest_t id_dest;

   initial assert (DEPTH >= 2) else $error("pi_back: DEPTH must be at least 2");

   always_comb begin
      id_dest.valid = id_in.valid;
      id_dest.we    = id_in.we;
      id_dest.rd    = id_in.rd;
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      stg[0] <= '0;
               else if (bubble) stg[0] <= '0;
               else             stg[0] <= id_dest;
            end
         end else begin : g_follow
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   // R8: a stall cycle leaves an empty slot in the first execute stage
   p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> !stg[0].valid);

   // R9: without a stall, decode content moves into EX1
   p_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bubble && id_in.valid) |=> (stg[0].valid && stg[0].rd == $past(id_in.rd)));

endmodule

// File: rtl/pi_hazard.sv
module pi_hazard
   import pi_pkg::*;
#(
   parameter int DEPTH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  front_t            id_in,
   input  dest_t [DEPTH-1:0] stg,
   output logic              stall
);

   localparam int RUN_W = $clog2(DEPTH + 2);

   logic [DEPTH-1:0] hit;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
         logic live;
         assign live   = stg[i].valid && stg[i].we && (stg[i].rd != '0);
         assign hit[i] = live && ((id_in.rs1 == stg[i].rd && id_in.rs1 != '0) ||
                                  (id_in.rs2 == stg[i].rd && id_in.rs2 != '0));
      end
   endgenerate

   assign stall = id_in.valid && (|hit);

   // checker: length of the current stall run
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (stall) run_q <= run_q + 1'b1;
      else            run_q <= '0;
   end

   // R3: a run can never outlast the producer's trip to writeback
   p_stall_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_W'(DEPTH));

   // R5: decode reading only register 0 is never held
   p_reg0_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (id_in.rs1 == '0 && id_in.rs2 == '0) |-> !stall);

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
   import pi_pkg::*;
#(
   parameter int EX_STAGES  = 2,
   parameter int MEM_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fetch_valid,
   input  logic                 fetch_we,
   input  logic [REG_IDX_W-1:0] fetch_rd,
   input  logic [REG_IDX_W-1:0] fetch_rs1,
   input  logic [REG_IDX_W-1:0] fetch_rs2,
   output logic                 fetch_ready,
   output logic                 stall,
   output logic                 ex1_valid,
   output logic [REG_IDX_W-1:0] ex1_rd,
   output logic                 wb_valid,
   output logic                 wb_we,
   output logic [REG_IDX_W-1:0] wb_rd
);

   localparam int FRONT_STAGES = 3;                       // IM1, IM2, ID
   localparam int BACK_STAGES  = EX_STAGES + MEM_STAGES + 1;

   initial assert (EX_STAGES >= 1 && MEM_STAGES >= 1)
      else $error("pipe_interlock: stage counts must be positive");

   front_t                  fetch_pkt;
   front_t                  id_pkt;
   dest_t [BACK_STAGES-1:0] back_stg;

   always_comb begin
      fetch_pkt.valid = fetch_valid;
      fetch_pkt.we    = fetch_we;
      fetch_pkt.rd    = fetch_rd;
      fetch_pkt.rs1   = fetch_rs1;
      fetch_pkt.rs2   = fetch_rs2;
   end

   pi_front #(.DEPTH(FRONT_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (stall),
      .fetch_in (fetch_pkt),
      .id_out   (id_pkt)
   );

   pi_hazard #(.DEPTH(BACK_STAGES)) u_hazard (
      .clk   (clk),
      .rst_n (rst_n),
      .id_in (id_pkt),
      .stg   (back_stg),
      .stall (stall)
   );

   pi_back #(.DEPTH(BACK_STAGES)) u_back (
      .clk    (clk),
      .rst_n  (rst_n),
      .bubble (stall),
      .id_in  (id_pkt),
      .stg    (back_stg)
   );

   assign fetch_ready = !stall;
   assign ex1_valid   = back_stg[0].valid;
   assign ex1_rd      = back_stg[0].rd;
   assign wb_valid    = back_stg[BACK_STAGES-1].valid;
   assign wb_we       = back_stg[BACK_STAGES-1].we;
   assign wb_rd       = back_stg[BACK_STAGES-1].rd;

   // R6: an instruction whose write-enable is low and is alone in the back end never holds decode
   p_no_we_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (back_stg[0].valid && !back_stg[0].we &&
       !back_stg[1].valid && !back_stg[2].valid && !back_stg[3].valid &&
       !back_stg[BACK_STAGES-1].valid) |-> !stall);

endmodule

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 400;
   localparam int NDIR       = 10;
   localparam int GAP_DEP    = 6;      // producer-to-consumer decode distance
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fetch_valid = 1'b0, fetch_we = 1'b0;
   logic [4:0] fetch_rd = '0, fetch_rs1 = '0, fetch_rs2 = '0;
   logic       fetch_ready, stall, ex1_valid, wb_valid, wb_we;
   logic [4:0] ex1_rd, wb_rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_interlock u_pipe_interlock (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_we(fetch_we),
      .fetch_rd(fetch_rd), .fetch_rs1(fetch_rs1), .fetch_rs2(fetch_rs2),
      .fetch_ready(fetch_ready), .stall(stall), .ex1_valid(ex1_valid),
      .ex1_rd(ex1_rd), .wb_valid(wb_valid), .wb_we(wb_we), .wb_rd(wb_rd)
   );

   logic [4:0] p_rd [N], p_rs1 [N], p_rs2 [N];
   logic       p_we [N];
   string      p_tag [N];
   int         exp_d [N];
   int         checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input int k, input bit we, input int rd, input int s1, input int s2,
                      input string tag);
      p_we[k] = we; p_rd[k] = 5'(rd); p_rs1[k] = 5'(s1); p_rs2[k] = 5'(s2); p_tag[k] = tag;
   endtask

   // decode-exit cycle model: consumer leaves decode no earlier than producer + 6
   function automatic void build_model();
      int ready [32];
      for (int r = 0; r < 32; r++) ready[r] = 0;
      for (int k = 0; k < N; k++) begin
         int d;
         d = (k == 0) ? 0 : exp_d[k-1] + 1;
         if (p_rs1[k] != 0 && ready[p_rs1[k]] > d) d = ready[p_rs1[k]];
         if (p_rs2[k] != 0 && ready[p_rs2[k]] > d) d = ready[p_rs2[k]];
         exp_d[k] = d;
         if (p_we[k] && p_rd[k] != 0) ready[p_rd[k]] = d + GAP_DEP;
      end
   endfunction

   initial begin
      int seed_v;
      int idx = 0, iss = 0, ret = 0, last_cyc = 0, cyc = 0;
      int stall_obs = 0, stall_exp = 0;
      bit prev_stall = 1'b0;
      seed_v = $urandom(32'h1F2E3D4C);

      // directed corner cases
      put(0, 1, 5, 0, 0, "R9");
      put(1, 1, 6, 5, 0, "R3");   // directly behind producer of r5
      put(2, 1, 7, 1, 2, "R9");
      put(3, 1, 0, 6, 0, "R4");   // two behind producer of r6, writes r0
      put(4, 1, 3, 0, 0, "R9");
      put(5, 1, 8, 0, 0, "R5");   // reads r0 just after an r0 write
      put(6, 0, 2, 0, 0, "R9");   // no write-enable
      put(7, 1, 9, 2, 2, "R6");   // reads r2 from the non-writing instruction
      put(8, 1, 4, 0, 0, "R9");
      put(9, 1, 1, 0, 4, "R2");   // second source hazard
      for (int k = NDIR; k < N; k++)
         put(k, ($urandom % 4) != 0, $urandom % 8, $urandom % 8, $urandom % 8, "R2");
      build_model();
      for (int k = 1; k < N; k++) stall_exp += exp_d[k] - exp_d[k-1] - 1;

      repeat (3) @(negedge clk);
      chk(!stall && fetch_ready && !ex1_valid && !wb_valid, "R1", stall, 0);
      rst_n = 1'b1;

      while ((iss < N || ret < N) && cyc < WATCHDOG) begin
         @(negedge clk);
         cyc++;
         if (prev_stall) chk(!ex1_valid, "R8 bubble", ex1_valid, 0);
         if (ex1_valid) begin
            if (iss < N) begin
               chk(ex1_rd == p_rd[iss], "R7 order", ex1_rd, p_rd[iss]);
               if (iss > 0)
                  chk(cyc - last_cyc == exp_d[iss] - exp_d[iss-1], p_tag[iss],
                      cyc - last_cyc, exp_d[iss] - exp_d[iss-1]);
            end else chk(1'b0, "R7 extra issue", iss, N);
            last_cyc = cyc;
            iss++;
         end
         if (wb_valid) begin
            if (ret < N) chk(wb_rd == p_rd[ret] && wb_we == p_we[ret], "R8 retire",
                             wb_rd, p_rd[ret]);
            ret++;
         end
         if (stall) begin
            stall_obs++;
            chk(!fetch_ready, "R7 ready", fetch_ready, 0);
         end
         prev_stall = stall;
         if (idx < N) begin
            fetch_valid = 1'b1; fetch_we = p_we[idx]; fetch_rd = p_rd[idx];
            fetch_rs1 = p_rs1[idx]; fetch_rs2 = p_rs2[idx];
            if (!stall) idx++;
         end else fetch_valid = 1'b0;
      end

      chk(cyc < WATCHDOG, "watchdog", cyc, WATCHDOG);
      chk(stall_obs == stall_exp, "R3 total stalls", stall_obs, stall_exp);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule